// File: doc/BRIEF.md
# Receive Self-Test Pattern Checker

This block sits behind the 8b/10b decoder on the receive side of a serial link and checks a built-in self-test stream. A pseudo-random generator inside it reproduces, character by character, the same sequence that a matching generator on the transmit side sends. The checker stays idle until self-test is enabled. It then waits for the start character, arms itself, and from that point compares every decoded character with the one it expected.

Each decoded character passes first through a registered output stage. The comparison reads the registered copy, so the output register is part of the path being tested. A mismatch raises a one-cycle error flag. A one-cycle loop pulse marks the start of every pass through the 511-character pattern. Decoder code-rule and disparity flags are deliberately not used as failures: the pattern contains violation symbols on purpose. The only way to restart the generator is to drop the enable and raise it again.

Top module: `rx_bist_checker`

## Requirements
- R1: While `rst` is high at a rising edge, and in the cycle after reset is released, `err_flag` and `loop_pulse` are low.
- R2: A character presented with `rx_valid` high at rising edge k is captured into the output register at edge k. Its result appears on `err_flag`/`loop_pulse` after edge k+1 and lasts one cycle. Both outputs are low in every cycle that does not carry a result for a valid character.
- R3: When `bist_en` is low at the edge where a character is captured, that character has no effect: both outputs stay low, the checker disarms, and the generator returns to its seed. This includes the start character.
- R4: When enabled but not yet armed, every character other than the start character gives `err_flag` low and `loop_pulse` low, and the generator holds its seed. The start character is data code 0x00 with `rx_special` = 0. Special code 0x00, the violation symbol, does not arm the checker.
- R5: The first start character after enable arms the checker and produces `loop_pulse` high with `err_flag` low. The next valid character is compared against position 1 of the sequence.
- R6: The generator is a 9-bit register seeded with 0x001. Each step shifts it one place toward the MSB and loads bit 8 XOR bit 4 into bit 0 (polynomial x^9 + x^5 + 1). It steps once per valid armed character, so the sequence repeats every 511 characters.
- R7: An expected character is built from v = state - 0x001 (modulo 512). Bit 8 of v is the special flag and bits 7:0 are the code. If the special flag is 0, the expected character is the data code v[7:0]. If the flag is 1 and the code is one of 1C, 3C, 5C, 7C, 9C, BC, DC, FC, F7, FB, FD, FE, the expected character is that special code. Any other special value expects the violation symbol, which is special flag 1 with code 0x00.
- R8: When armed, a character that differs from the expected one in code or special flag raises `err_flag` for its result cycle. The generator still advances, so the following characters are compared at the next positions.
- R9: `rx_code_err` and `rx_disp_err` never affect `err_flag` or `loop_pulse`.
- R10: When armed, `loop_pulse` is high for the character compared at sequence position 0, whether or not that character matches. This happens once every 511 armed characters.
- R11: A start character received while armed is compared like any other character and does not restart the sequence. Lowering and raising `bist_en` and then sending a start character restarts it at position 0.
- R12: Cycles with `rx_valid` low do not advance the generator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| bist_en | input | 1 | Self-test enable |
| rx_valid | input | 1 | Decoded character strobe |
| rx_data | input | 8 | Decoded character code |
| rx_special | input | 1 | High for special characters |
| rx_code_err | input | 1 | Decoder code-rule violation flag |
| rx_disp_err | input | 1 | Decoder running-disparity error flag |
| err_flag | output | 1 | Pattern mismatch, one cycle per bad character |
| loop_pulse | output | 1 | One cycle at each start of the pattern loop |

## Verification
The bench drives a start character while self-test is disabled and again before arming. A checker that armed from a stale enable, or from the special code 0x00, would begin flagging errors too early. It sends violation symbols with the code-error flag set and correct characters with the disparity flag set; a design that counted decoder flags as failures would report false errors. It injects a wrong character, a stray start character and valid-low gaps in mid-loop. A generator that stalled on errors, re-armed on the stray start character, or stepped during gaps would shift every later comparison. It also places a bad character exactly at the loop wrap, where the error and the loop pulse must both appear, and then checks that toggling the enable restarts the sequence from position 0.

// File: rtl/rxbist_pkg.sv
package rxbist_pkg;

   // number of legal special codes in the character set
   localparam int unsigned NUM_KCODES = 12;
   localparam int unsigned KCODE_W    = 8;

   // legal special code values, packed eight bits each
   localparam logic [NUM_KCODES*KCODE_W-1:0] KCODE_SET = {
      8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC,
      8'hDC, 8'hFC, 8'hF7, 8'hFB, 8'hFD, 8'hFE
   };

   // code carried with the special flag to mark a violation symbol
   localparam logic [KCODE_W-1:0] VIOL_CODE = 8'h00;

endpackage

// File: rtl/rxbist_capture.sv
module rxbist_capture #(
   parameter int unsigned SYM_W = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_en,
   input  logic             in_vld,
   input  logic [SYM_W-1:0] in_sym,
   input  logic             in_dec_err,
   output logic             q_en,
   output logic             q_vld,
   output logic [SYM_W-1:0] q_sym,
   output logic             q_dec_err
);

   if (SYM_W < 2) begin : g_bad_width
      $error("rxbist_capture: SYM_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         q_en      <= 1'b0;
         q_vld     <= 1'b0;
         q_sym     <= '0;
         q_dec_err <= 1'b0;
      end else begin
         q_en      <= in_en;
         q_vld     <= in_vld;
         q_sym     <= in_sym;
         q_dec_err <= in_vld & in_dec_err;
      end
   end

endmodule

// File: rtl/rxbist_prbs.sv
module rxbist_prbs #(
   parameter int unsigned      W    = 9,
   parameter int unsigned      TAP  = 5,
   parameter logic [W-1:0]     SEED = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         hold_seed,
   input  logic         step,
   output logic [W-1:0] state
);

   if (W < 3) begin : g_bad_w
      $error("rxbist_prbs: W must be at least 3");
   end
   if (TAP == 0 || TAP >= W) begin : g_bad_tap
      $error("rxbist_prbs: TAP must lie between 1 and W-1");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("rxbist_prbs: SEED must be nonzero");
   end

   logic [W-1:0] nxt;
   assign nxt = {state[W-2:0], state[W-1] ^ state[TAP-1]};

   always_ff @(posedge clk) begin
      if (rst || hold_seed) begin
         state <= SEED;
      end else if (step) begin
         state <= nxt;
      end
   end

endmodule

// File: rtl/rxbist_symmap.sv
module rxbist_symmap
   import rxbist_pkg::*;
#(
   parameter int unsigned  W    = 9,
   parameter logic [W-1:0] SEED = 1
) (
   input  logic [W-1:0] state,
   output logic [W-1:0] exp_sym
);

   localparam int unsigned CODE_W = W - 1;

   if (CODE_W != KCODE_W) begin : g_bad_code_w
      $error("rxbist_symmap: code width must match the special code set");
   end

   logic [W-1:0]          pos;
   logic [NUM_KCODES-1:0] k_hit;

   // position in the loop: the seed state is position 0
   assign pos = state - SEED;

   for (genvar i = 0; i < NUM_KCODES; i++) begin : g_kcmp
      assign k_hit[i] = (pos[CODE_W-1:0] == KCODE_SET[i*KCODE_W +: KCODE_W]);
   end

   always_comb begin
      if (!pos[W-1] || (|k_hit)) begin
         exp_sym = pos;
      end else begin
         exp_sym = {1'b1, VIOL_CODE};
      end
   end

endmodule

// File: rtl/rxbist_ctrl.sv
module rxbist_ctrl #(
   parameter int unsigned  W             = 9,
   parameter logic [W-1:0] SEED          = 1,
   parameter bit           DEC_ERR_FAILS = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         q_en,
   input  logic         q_vld,
   input  logic [W-1:0] q_sym,
   input  logic         q_dec_err,
   input  logic [W-1:0] exp_sym,
   input  logic [W-1:0] prbs_state,
   output logic         armed,
   output logic         prbs_hold,
   output logic         prbs_step,
   output logic         err,
   output logic         pulse
);

   logic start_hit;
   logic mism;

   // start character: data code zero with the special flag clear
   assign start_hit = q_vld && (q_sym == '0);
   assign mism      = (q_sym != exp_sym) || (DEC_ERR_FAILS && q_dec_err);

   assign prbs_hold = !q_en;
   assign prbs_step = q_en && q_vld && (armed || start_hit);

   always_ff @(posedge clk) begin
      if (rst || !q_en) begin
         armed <= 1'b0;
         err   <= 1'b0;
         pulse <= 1'b0;
      end else if (!armed) begin
         armed <= start_hit;
         err   <= 1'b0;
         pulse <= start_hit;
      end else begin
         err   <= q_vld && mism;
         pulse <= q_vld && (prbs_state == SEED);
      end
   end

endmodule

// File: rtl/rx_bist_checker.sv
module rx_bist_checker #(
   parameter int unsigned           DATA_W        = 8,
   parameter int unsigned           TAP           = 5,
   parameter logic [DATA_W:0]       SEED          = 1,
   parameter bit                    DEC_ERR_FAILS = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bist_en,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_special,
   input  logic              rx_code_err,
   input  logic              rx_disp_err,
   output logic              err_flag,
   output logic              loop_pulse
);

   localparam int unsigned LFSR_W = DATA_W + 1;

   logic              cap_en;
   logic              cap_vld;
   logic [LFSR_W-1:0] cap_sym;
   logic              cap_dec_err;
   logic [LFSR_W-1:0] lfsr_st;
   logic [LFSR_W-1:0] exp_sym;
   logic              armed_w;
   logic              prbs_hold;
   logic              prbs_step;

   rxbist_capture #(.SYM_W(LFSR_W)) u_cap (
      .clk        (clk),
      .rst        (rst),
      .in_en      (bist_en),
      .in_vld     (rx_valid),
      .in_sym     ({rx_special, rx_data}),
      .in_dec_err (rx_code_err | rx_disp_err),
      .q_en       (cap_en),
      .q_vld      (cap_vld),
      .q_sym      (cap_sym),
      .q_dec_err  (cap_dec_err)
   );

   rxbist_prbs #(.W(LFSR_W), .TAP(TAP), .SEED(SEED)) u_prbs (
      .clk       (clk),
      .rst       (rst),
      .hold_seed (prbs_hold),
      .step      (prbs_step),
      .state     (lfsr_st)
   );

   rxbist_symmap #(.W(LFSR_W), .SEED(SEED)) u_map (
      .state   (lfsr_st),
      .exp_sym (exp_sym)
   );

   rxbist_ctrl #(.W(LFSR_W), .SEED(SEED), .DEC_ERR_FAILS(DEC_ERR_FAILS)) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .q_en       (cap_en),
      .q_vld      (cap_vld),
      .q_sym      (cap_sym),
      .q_dec_err  (cap_dec_err),
      .exp_sym    (exp_sym),
      .prbs_state (lfsr_st),
      .armed      (armed_w),
      .prbs_hold  (prbs_hold),
      .prbs_step  (prbs_step),
      .err        (err_flag),
      .pulse      (loop_pulse)
   );

endmodule

// File: rtl/rx_bist_checker_sva.sv
module rx_bist_checker_sva #(
   parameter int unsigned      LFSR_W = 9,
   parameter logic [LFSR_W-1:0] SEED  = 1
) (
   input logic              clk,
   input logic              rst,
   input logic              bist_en,
   input logic              rx_valid,
   input logic              err_flag,
   input logic              loop_pulse,
   input logic              armed,
   input logic              cap_en,
   input logic              cap_vld,
   input logic [LFSR_W-1:0] lfsr_st
);

   logic en_d1, en_d2, vld_d1, vld_d2;

   always_ff @(posedge clk) begin
      if (rst) begin
         en_d1  <= 1'b0;
         en_d2  <= 1'b0;
         vld_d1 <= 1'b0;
         vld_d2 <= 1'b0;
      end else begin
         en_d1  <= bist_en;
         en_d2  <= en_d1;
         vld_d1 <= rx_valid;
         vld_d2 <= vld_d1;
      end
   end

   a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
      !en_d2 |-> (!err_flag && !loop_pulse));

   a_r2_err_needs_char: assert property (@(posedge clk) disable iff (rst)
      err_flag |-> vld_d2);

   a_r2_pulse_needs_char: assert property (@(posedge clk) disable iff (rst)
      loop_pulse |-> vld_d2);

   a_r4_seed_until_armed: assert property (@(posedge clk) disable iff (rst)
      !armed |-> (lfsr_st == SEED));

   a_r11_disarm_on_disable: assert property (@(posedge clk) disable iff (rst)
      !cap_en |=> !armed);

   a_r12_gap_holds: assert property (@(posedge clk) disable iff (rst)
      (armed && cap_en && !cap_vld) |=> $stable(lfsr_st));

   a_r6_steps_per_char: assert property (@(posedge clk) disable iff (rst)
      (armed && cap_en && cap_vld) |=> (lfsr_st != $past(lfsr_st)));

   a_r6_never_zero: assert property (@(posedge clk) disable iff (rst)
      lfsr_st != '0);

endmodule

bind rx_bist_checker rx_bist_checker_sva #(.LFSR_W(LFSR_W), .SEED(SEED)) u_sva (
   .clk        (clk),
   .rst        (rst),
   .bist_en    (bist_en),
   .rx_valid   (rx_valid),
   .err_flag   (err_flag),
   .loop_pulse (loop_pulse),
   .armed      (armed_w),
   .cap_en     (cap_en),
   .cap_vld    (cap_vld),
   .lfsr_st    (lfsr_st)
);

// File: tb/rx_bist_checker_tb_top.sv
module rx_bist_checker_tb_top;

   localparam logic [8:0] SEED = 9'h001;
   localparam logic [8:0] VIOL = 9'h100;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bist_en = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       rx_special = 1'b0;
   logic       rx_code_err = 1'b0;
   logic       rx_disp_err = 1'b0;
   logic       err_flag;
   logic       loop_pulse;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct { bit e; bit p; string tag; } item_t;
   item_t sb_q[$];

   bit         m_armed = 1'b0;
   logic [8:0] m_st = SEED;
   logic [1:0] pipe = '0;
   int         nsent = 0;

   always #10 clk = ~clk;

   rx_bist_checker dut_i (
      .clk         (clk),
      .rst         (rst),
      .bist_en     (bist_en),
      .rx_valid    (rx_valid),
      .rx_data     (rx_data),
      .rx_special  (rx_special),
      .rx_code_err (rx_code_err),
      .rx_disp_err (rx_disp_err),
      .err_flag    (err_flag),
      .loop_pulse  (loop_pulse)
   );

   function automatic logic [8:0] nxt(input logic [8:0] s);
      return {s[7:0], s[8] ^ s[4]};
   endfunction

   function automatic logic [8:0] exp_of(input logic [8:0] s);
      logic [8:0] v;
      v = s - SEED;
      if (!v[8]) return v;
      case (v[7:0])
         8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC,
         8'hF7, 8'hFB, 8'hFD, 8'hFE: return v;
         default: return VIOL;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   task automatic send(input logic [8:0] sym, input bit cerr, input bit derr,
                       input string tag);
      bit e, p;
      @(posedge clk); #2;
      rx_valid = 1'b1;
      {rx_special, rx_data} = sym;
      rx_code_err = cerr;
      rx_disp_err = derr;
      e = 1'b0; p = 1'b0;
      if (!bist_en) begin
         m_armed = 1'b0; m_st = SEED;
      end else if (!m_armed) begin
         if (sym == 9'h000) begin
            m_armed = 1'b1; p = 1'b1; m_st = nxt(SEED);
         end
      end else begin
         e = (sym != exp_of(m_st));
         p = (m_st == SEED);
         m_st = nxt(m_st);
      end
      nsent++;
      sb_q.push_back('{e, p, tag});
   endtask

   task automatic send_good(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         logic [8:0] s;
         s = exp_of(m_st);
         // R9: violation symbols arrive with the code error flag set
         send(s, s == VIOL, (nsent % 5) == 0, tag);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #2;
         rx_valid = 1'b0; rx_code_err = 1'b0; rx_disp_err = 1'b0;
      end
   endtask

   task automatic set_en(input bit v);
      @(posedge clk); #2;
      rx_valid = 1'b0;
      bist_en = v;
      if (!v) begin m_armed = 1'b0; m_st = SEED; end
   endtask

   // monitor: pops scoreboard items two edges after the character was driven
   always @(negedge clk) begin
      if (rst) begin
         pipe = '0;
      end else begin
         if (pipe[1]) begin
            if (sb_q.size() == 0) begin
               check(1'b0, "R2", "result with empty scoreboard", 1, 0);
            end else begin
               item_t it;
               it = sb_q.pop_front();
               check(err_flag == it.e, it.tag, "err_flag", err_flag, it.e);
               check(loop_pulse == it.p, "R10", "loop_pulse", loop_pulse, it.p);
            end
         end else begin
            check(!err_flag && !loop_pulse, "R2", "outputs without character",
                  {err_flag, loop_pulse}, 0);
         end
         pipe = {pipe[0], rx_valid};
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!err_flag && !loop_pulse, "R1", "outputs in reset", {err_flag, loop_pulse}, 0);
      @(posedge clk); #2;
      rst = 1'b0;
      @(negedge clk);
      check(!err_flag && !loop_pulse, "R1", "outputs after reset", {err_flag, loop_pulse}, 0);

      // R3: disabled, start character and junk are ignored
      send(9'h000, 0, 0, "R3");
      send(9'h0A5, 0, 0, "R3");
      send(9'h000, 0, 0, "R3");
      idle(3);

      // R4: enabled, not armed; violation symbol must not arm
      set_en(1'b1);
      send(9'h0BC, 0, 0, "R4");
      send(VIOL, 1, 0, "R4");
      send(9'h1BC, 0, 1, "R4");
      idle(2);

      // R5: arm on the start character, then R6/R7/R9 on good traffic
      send(9'h000, 0, 0, "R5");
      send_good(40, "R7");

      // R8: single wrong character, sequence keeps advancing
      send(exp_of(m_st) ^ 9'h001, 0, 0, "R8");
      send_good(20, "R8");
      // R9: wrong-free character with both decoder flags set
      send(exp_of(m_st), 1, 1, "R9");

      // R11: stray start character while armed is a plain mismatch
      if (exp_of(m_st) == 9'h000) send_good(1, "R11");
      send(9'h000, 0, 0, "R11");
      send_good(5, "R11");

      // R12: gaps do not advance the generator
      idle(4);
      send_good(10, "R12");

      // R6/R10: run to the wrap and put a bad character on position 0
      while (m_st != SEED) send_good(1, "R6");
      send(9'h0FF, 0, 0, "R10");
      send_good(30, "R10");

      // R3: disable mid-loop, mismatches are ignored
      set_en(1'b0);
      send(9'h055, 0, 0, "R3");
      send(9'h000, 0, 0, "R3");
      idle(2);

      // R11: re-enable needs a fresh start character
      set_en(1'b1);
      send(9'h033, 0, 0, "R4");
      send(9'h000, 0, 0, "R11");
      send_good(10, "R11");
      idle(4);

      check(sb_q.size() == 0, "R2", "scoreboard drained", sb_q.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule